// File: doc/BRIEF.md
# Per-User Repeated Over-Threshold Interlock

This block decides, for each beam user, whether injections may continue. At the end of every machine cycle the loss maxima of four integration windows arrive for each channel, one channel per clock, tagged with the user that owned the cycle. Each maximum is compared against a threshold chosen by user, channel and window. A per-user, per-channel counter tracks how often that channel has been over threshold for that user. When the counter reaches the repeat number configured for the channel, the user is blocked. The block holds until an operator acknowledge that names the user arrives.

Before each cycle the announced user is presented on a query port. One clock later the block returns a give or remove permit answer for that user. The counter runs in one of two modes. In consecutive mode, which is the default, a clean result clears the count. In cumulative mode the count only grows.

Top module: `user_repeat_interlock`

## Requirements
- R1: Each (user, channel) pair owns four thresholds, one per window, written as one word with window w in bits [16w+15:16w]. A channel result is over threshold when any window maximum is strictly greater than that window's threshold. A maximum equal to its threshold is clean.
- R2: Each channel has a repeat number, 1 after reset. A written value of 0 is stored as 1, and a value above 16 is stored as 16.
- R3: With `cfg_cumulative`=0, an over result adds one to the user-channel counter and a clean result sets it to zero.
- R4: With `cfg_cumulative`=1, a clean result leaves the counter unchanged. The counter saturates at 16.
- R5: When an over result makes the counter equal to or greater than the channel's repeat number, the user becomes blocked. A query presented two or more clocks after the result is accepted returns permit 0.
- R6: An acknowledge for a user clears that user's block and all of that user's counters. A trip for the same user that is processed in the same clock wins, and the user stays blocked.
- R7: After reset no user is blocked and `perm_valid` is 0. A query accepted on one clock gives `perm_valid`=1 on the next clock, with `permit`=1 exactly when the user is not blocked.
- R8: Counters and blocks of different users are independent. A result or acknowledge for one user never changes the permit of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cumulative | input | 1 | 0: consecutive counting, 1: cumulative counting |
| thr_we | input | 1 | Threshold write strobe |
| thr_user | input | 5 | User of threshold write |
| thr_ch | input | 3 | Channel of threshold write |
| thr_data | input | 64 | Four 16-bit window thresholds |
| rep_we | input | 1 | Repeat number write strobe |
| rep_ch | input | 3 | Channel of repeat write |
| rep_n | input | 5 | Repeat number (clamped to 1..16) |
| ev_valid | input | 1 | End-of-cycle maxima valid |
| ev_user | input | 5 | User that owned the finished cycle |
| ev_ch | input | 3 | Channel of the maxima |
| ev_max | input | 64 | Four 16-bit window maxima |
| ack_valid | input | 1 | Operator acknowledge strobe |
| ack_user | input | 5 | User to release |
| q_valid | input | 1 | Permit query strobe |
| q_user | input | 5 | Announced user for next cycle |
| perm_valid | output | 1 | Permit answer valid |
| permit | output | 1 | 1 = give permit, 0 = remove permit |

## Verification
On every clock the assertions check several things. A trip sets the user's block, and a block persists until an acknowledge for that user. An acknowledge releases a block unless a trip for the same user is processed in the same clock. The query answer appears exactly one clock later, a blocked user is never given permit, and stored repeat numbers stay in the range 1 to 16. Other behaviours can only be shown by the bench's scenarios, because they need whole sequences of cycles. These are the strict comparison at the threshold edge, the selection of the exceeding window, consecutive counts broken by a clean cycle, cumulative counts across clean cycles, clamping of the repeat number, the counter reset done by an acknowledge, and the isolation of one user from another.

// File: rtl/ui_pkg.sv
package ui_pkg;
  typedef enum logic {
    CNT_CONSEC = 1'b0,
    CNT_CUMUL  = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/ui_thr_ram.sv
module ui_thr_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ui_win_cmp.sv
module ui_win_cmp #(
  parameter int N_WIN = 4,
  parameter int VAL_W = 16
) (
  input  logic [N_WIN*VAL_W-1:0] max_vec,
  input  logic [N_WIN*VAL_W-1:0] thr_vec,
  output logic                   over
);
  logic [N_WIN-1:0] hit;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    assign hit[w] = max_vec[w*VAL_W +: VAL_W] > thr_vec[w*VAL_W +: VAL_W];
  end

  assign over = |hit;
endmodule

// File: rtl/user_repeat_interlock.sv
module user_repeat_interlock
  import ui_pkg::*;
#(
  parameter int N_USERS = 32,
  parameter int N_CH    = 8,
  parameter int N_WIN   = 4,
  parameter int VAL_W   = 16,
  parameter int MAX_REP = 16,
  parameter int DEF_REP = 1,
  localparam int UW = $clog2(N_USERS),
  localparam int CW = $clog2(N_CH),
  localparam int RW = $clog2(MAX_REP + 1),
  localparam int DW = N_WIN * VAL_W,
  localparam int AW = $clog2(N_USERS * N_CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_cumulative,
  input  logic          thr_we,
  input  logic [UW-1:0] thr_user,
  input  logic [CW-1:0] thr_ch,
  input  logic [DW-1:0] thr_data,
  input  logic          rep_we,
  input  logic [CW-1:0] rep_ch,
  input  logic [RW-1:0] rep_n,
  input  logic          ev_valid,
  input  logic [UW-1:0] ev_user,
  input  logic [CW-1:0] ev_ch,
  input  logic [DW-1:0] ev_max,
  input  logic          ack_valid,
  input  logic [UW-1:0] ack_user,
  input  logic          q_valid,
  input  logic [UW-1:0] q_user,
  output logic          perm_valid,
  output logic          permit
);
  localparam logic [RW-1:0] REP_HI = RW'(MAX_REP);

  // stage 1: event waiting for its thresholds
  logic          s1_valid;
  logic [UW-1:0] s1_user;
  logic [CW-1:0] s1_ch;
  logic [DW-1:0] s1_max;
  logic [DW-1:0] thr_rd;

  logic [RW-1:0]      cnt_q   [N_USERS][N_CH];
  logic [RW-1:0]      rep_q   [N_CH];
  logic [N_USERS-1:0] blocked_q;

  logic          over;
  logic          ack_hit;
  logic [RW-1:0] cnt_base;
  logic [RW-1:0] cnt_next;
  logic          trip;
  logic [RW-1:0] rep_clamped;
  cnt_mode_e     mode;

  ui_thr_ram #(.DEPTH(N_USERS * N_CH), .W(DW)) thr_ram_i (
    .clk   (clk),
    .we    (thr_we),
    .waddr (AW'(int'(thr_user) * N_CH + int'(thr_ch))),
    .wdata (thr_data),
    .re    (ev_valid),
    .raddr (AW'(int'(ev_user) * N_CH + int'(ev_ch))),
    .rdata (thr_rd)
  );

  ui_win_cmp #(.N_WIN(N_WIN), .VAL_W(VAL_W)) win_cmp_i (
    .max_vec (s1_max),
    .thr_vec (thr_rd),
    .over    (over)
  );

  assign mode = cnt_mode_e'(cfg_cumulative);

  always_comb begin
    ack_hit  = ack_valid && (ack_user == s1_user);
    cnt_base = ack_hit ? '0 : cnt_q[s1_user][s1_ch];
    if (over)
      cnt_next = (cnt_base >= REP_HI) ? REP_HI : cnt_base + 1'b1;
    else if (mode == CNT_CUMUL)
      cnt_next = cnt_base;
    else
      cnt_next = '0;
    trip = s1_valid && over && (cnt_next >= rep_q[s1_ch]);

    if (rep_n == '0)         rep_clamped = RW'(1);
    else if (rep_n > REP_HI) rep_clamped = REP_HI;
    else                     rep_clamped = rep_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_user    <= '0;
      s1_ch      <= '0;
      s1_max     <= '0;
      blocked_q  <= '0;
      perm_valid <= 1'b0;
      permit     <= 1'b0;
      for (int u = 0; u < N_USERS; u++)
        for (int c = 0; c < N_CH; c++)
          cnt_q[u][c] <= '0;
      for (int c = 0; c < N_CH; c++)
        rep_q[c] <= RW'(DEF_REP);
    end else begin
      s1_valid <= ev_valid;
      if (ev_valid) begin
        s1_user <= ev_user;
        s1_ch   <= ev_ch;
        s1_max  <= ev_max;
      end

      if (rep_we) rep_q[rep_ch] <= rep_clamped;

      for (int u = 0; u < N_USERS; u++) begin
        if (ack_valid && ack_user == UW'(u)) begin
          for (int c = 0; c < N_CH; c++) cnt_q[u][c] <= '0;
        end
      end
      if (s1_valid) cnt_q[s1_user][s1_ch] <= cnt_next;

      for (int u = 0; u < N_USERS; u++) begin
        if (trip && s1_user == UW'(u))
          blocked_q[u] <= 1'b1;
        else if (ack_valid && ack_user == UW'(u))
          blocked_q[u] <= 1'b0;
      end

      perm_valid <= q_valid;
      permit     <= q_valid && !blocked_q[q_user];
    end
  end

  // R5: a trip always leaves the user blocked
  a_r5_trip_blocks : assert property (@(posedge clk) disable iff (rst)
    trip |=> blocked_q[$past(s1_user)]);

  // R6: an acknowledge releases unless a same-user trip coincides
  a_r6_ack_releases : assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !(trip && s1_user == ack_user)) |=> !blocked_q[$past(ack_user)]);

  for (genvar u = 0; u < N_USERS; u++) begin : g_sticky
    // R6: no block disappears without an acknowledge for its own user
    a_r6_block_sticky : assert property (@(posedge clk) disable iff (rst)
      (blocked_q[u] && !(ack_valid && ack_user == UW'(u))) |=> blocked_q[u]);
  end

  // R7: answer one clock after the query, and only then
  a_r7_answer_latency : assert property (@(posedge clk) disable iff (rst)
    q_valid |=> perm_valid);
  a_r7_no_spurious_answer : assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> !perm_valid);
  a_r7_blocked_denied : assert property (@(posedge clk) disable iff (rst)
    (q_valid && blocked_q[q_user]) |=> !permit);

  for (genvar c = 0; c < N_CH; c++) begin : g_rep
    // R2: stored repeat numbers stay within 1..MAX_REP
    a_r2_rep_range : assert property (@(posedge clk) disable iff (rst)
      rep_we |=> (rep_q[c] != '0) && (rep_q[c] <= REP_HI));
  end
endmodule

// File: tb/user_repeat_interlock_tb_top.sv
module user_repeat_interlock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_cumulative = 1'b0;
  logic        thr_we = 1'b0;
  logic [4:0]  thr_user = '0;
  logic [2:0]  thr_ch = '0;
  logic [63:0] thr_data = '0;
  logic        rep_we = 1'b0;
  logic [2:0]  rep_ch = '0;
  logic [4:0]  rep_n = '0;
  logic        ev_valid = 1'b0;
  logic [4:0]  ev_user = '0;
  logic [2:0]  ev_ch = '0;
  logic [63:0] ev_max = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_user = '0;
  logic        q_valid = 1'b0;
  logic [4:0]  q_user = '0;
  logic        perm_valid;
  logic        permit;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  user_repeat_interlock dut_i (
    .clk(clk), .rst(rst), .cfg_cumulative(cfg_cumulative),
    .thr_we(thr_we), .thr_user(thr_user), .thr_ch(thr_ch), .thr_data(thr_data),
    .rep_we(rep_we), .rep_ch(rep_ch), .rep_n(rep_n),
    .ev_valid(ev_valid), .ev_user(ev_user), .ev_ch(ev_ch), .ev_max(ev_max),
    .ack_valid(ack_valid), .ack_user(ack_user),
    .q_valid(q_valid), .q_user(q_user),
    .perm_valid(perm_valid), .permit(permit)
  );

  // behavioural reference model
  int m_thr [32][8][4];
  int m_cnt [32][8];
  int m_rep [8];
  bit m_blk [32];
  bit pend_valid;
  int pend_user, pend_ch;
  bit pend_over;
  bit exp_pv, exp_perm;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cnt[u, c]) m_cnt[u][c] = 0;
      foreach (m_blk[u]) m_blk[u] = 0;
      foreach (m_rep[c]) m_rep[c] = 1;
      pend_valid = 0;
      exp_pv = 0;
      exp_perm = 0;
    end else begin
      int base, nxt;
      bit trip;
      exp_pv   = q_valid;
      exp_perm = q_valid && !m_blk[q_user];
      trip = 0;
      nxt  = 0;
      if (pend_valid) begin
        base = (ack_valid && int'(ack_user) == pend_user) ? 0 : m_cnt[pend_user][pend_ch];
        if (pend_over) nxt = (base >= 16) ? 16 : base + 1;
        else           nxt = cfg_cumulative ? base : 0;
        trip = pend_over && (nxt >= m_rep[pend_ch]);
      end
      if (ack_valid) begin
        for (int c = 0; c < 8; c++) m_cnt[ack_user][c] = 0;
        m_blk[ack_user] = 0;
      end
      if (pend_valid) m_cnt[pend_user][pend_ch] = nxt;
      if (trip) m_blk[pend_user] = 1;
      if (rep_we) m_rep[rep_ch] = (rep_n == 0) ? 1 : (rep_n > 16) ? 16 : int'(rep_n);
      pend_valid = ev_valid;
      if (ev_valid) begin
        pend_user = ev_user;
        pend_ch   = ev_ch;
        pend_over = 0;
        for (int w = 0; w < 4; w++)
          if (int'(ev_max[w*16 +: 16]) > m_thr[ev_user][ev_ch][w]) pend_over = 1;
      end
      if (thr_we)
        for (int w = 0; w < 4; w++) m_thr[thr_user][thr_ch][w] = int'(thr_data[w*16 +: 16]);
    end
  end

  // R7: per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (perm_valid !== exp_pv || (exp_pv && permit !== exp_perm)) begin
        fails++;
        $display("FAIL R7 model: perm_valid=%0b permit=%0b expected perm_valid=%0b permit=%0b",
                 perm_valid, permit, exp_pv, exp_perm);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_thr(input int u, input int c, input logic [63:0] d);
    @(negedge clk);
    thr_we = 1; thr_user = 5'(u); thr_ch = 3'(c); thr_data = d;
    @(negedge clk);
    thr_we = 0;
  endtask

  task automatic wr_rep(input int c, input int n);
    @(negedge clk);
    rep_we = 1; rep_ch = 3'(c); rep_n = 5'(n);
    @(negedge clk);
    rep_we = 0;
  endtask

  task automatic eval(input int u, input int c, input logic [63:0] m);
    @(negedge clk);
    ev_valid = 1; ev_user = 5'(u); ev_ch = 3'(c); ev_max = m;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic ack(input int u);
    @(negedge clk);
    ack_valid = 1; ack_user = 5'(u);
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic query(input int u, input bit exp, input string tag);
    repeat (2) @(negedge clk);
    q_valid = 1; q_user = 5'(u);
    @(negedge clk);
    q_valid = 0;
    chk(perm_valid === 1'b1 && permit === exp, tag, int'(permit), int'(exp));
  endtask

  localparam logic [63:0] OVER  = {4{16'd1500}};
  localparam logic [63:0] CLEAN = 64'd0;

  task automatic run();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(perm_valid === 1'b0, "R7 reset perm_valid", int'(perm_valid), 0);
    for (int u = 0; u < 4; u++)
      for (int c = 0; c < 8; c++) wr_thr(u, c, {4{16'd1000}});

    query(1, 1, "R7 unblocked after reset");
    eval(1, 2, {4{16'd1000}});
    query(1, 1, "R1 equal is clean");
    eval(1, 2, {16'd1001, 48'd0});
    query(1, 0, "R5 trip at default repeat 1 (R2)");
    query(2, 1, "R8 other user unaffected");
    ack(1);
    query(1, 1, "R6 ack releases");

    wr_thr(2, 0, {16'd40, 16'd30, 16'd20, 16'd10});
    eval(2, 0, {16'd5, 16'd5, 16'd25, 16'd5});
    query(2, 0, "R1 window 1 exceeds own threshold");
    ack(2);

    wr_rep(4, 3);
    cfg_cumulative = 0;
    eval(2, 4, OVER); eval(2, 4, OVER);
    query(2, 1, "R3 two of three");
    eval(2, 4, CLEAN);
    eval(2, 4, OVER); eval(2, 4, OVER);
    query(2, 1, "R3 clean breaks the run");
    eval(2, 4, OVER);
    query(2, 0, "R3 three consecutive trip");
    ack(2);

    cfg_cumulative = 1;
    eval(3, 4, OVER); eval(3, 4, CLEAN); eval(3, 4, OVER); eval(3, 4, CLEAN);
    query(3, 1, "R4 two cumulative");
    eval(3, 4, OVER);
    query(3, 0, "R4 third cumulative trips");

    cfg_cumulative = 0;
    eval(0, 2, OVER);
    query(0, 0, "R5 user 0 trips");
    ack(0);
    query(0, 1, "R6 user 0 released");
    query(3, 0, "R8 user 3 still blocked");

    ack(3);
    cfg_cumulative = 1;
    eval(3, 4, OVER);
    query(3, 1, "R6 ack cleared counters");
    eval(3, 4, OVER); eval(3, 4, OVER);
    query(3, 0, "R4 recount to three");
    ack(3);

    cfg_cumulative = 0;
    wr_rep(5, 0);
    eval(1, 5, OVER);
    query(1, 0, "R2 zero repeat acts as 1");
    ack(1);

    cfg_cumulative = 1;
    wr_rep(6, 20);
    for (int i = 0; i < 15; i++) eval(1, 6, OVER);
    query(1, 1, "R2 clamp to 16 (15 overs)");
    eval(1, 6, OVER);
    query(1, 0, "R2 clamp to 16 (16th trips)");
    ack(1);
    query(1, 1, "R6 release after clamp test");

    cfg_cumulative = 0;
    @(negedge clk);
    ev_valid = 1; ev_user = 5'd0; ev_ch = 3'd2; ev_max = OVER;
    @(negedge clk);
    ev_valid = 0; ack_valid = 1; ack_user = 5'd0;
    @(negedge clk);
    ack_valid = 0;
    query(0, 0, "R6 trip wins over same-clock ack");
    ack(0);
    query(0, 1, "R6 later ack releases");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule